// File: doc/BRIEF.md
# Line error event status monitor

This block sits behind a T1/E1 receive framer. It turns single-cycle error strobes into processor-visible status bits, one bit per error class. There are five classes: frame-bit errors, multiframe alignment errors, signalling (CAS) multiframe errors, CRC errors and pulse density violations. The last class comes from a detector inside the block that watches the received bitstream. A per-bit interrupt enable mask selects which status bits drive the interrupt line. The processor reads the status through a single read strobe.

Two reporting modes exist. In live mode each status bit is sticky and is cleared by a read. In interval-latch mode, events are accumulated in a hidden shadow register. On each one-second tick the shadow is copied into a held snapshot and the shadow is cleared. The status output and reads then return that snapshot, unchanged, until the next tick.

The mode controller has three states:
- `ST_LIVE`: sticky status with clear-on-read.
- `ST_ARM`: latch mode is enabled but no tick has arrived yet, so the snapshot is empty.
- `ST_HOLD`: a snapshot is being presented.

Its transitions are:
- LIVE→ARM when the latch enable rises.
- ARM→HOLD on a tick.
- HOLD→HOLD on each further tick, which takes a new snapshot.
- ARM→LIVE and HOLD→LIVE when the latch enable falls. Leaving latch mode starts live status empty.

Top module: `line_err_mon`

## Requirements
- R1: After reset, the status output, the read data and the interrupt line are all zero.
- R2: In live mode, an accepted strobe sets its status bit on the next clock edge. The bit stays set while no read occurs. Bit positions are: 0 frame-bit, 1 multiframe alignment, 2 CAS multiframe, 3 CRC, 4 pulse density.
- R3: In live mode, a read returns the status value on the edge of the read strobe and clears every status bit.
- R4: An event that arrives in the same cycle as a clearing read is not lost. Its bit is set after the read, and the read data does not include it.
- R5: A multiframe alignment strobe is accepted only when E1 mode and CRC4 framing are both selected. A CAS strobe is accepted only when E1 mode and CAS framing are both selected. Otherwise each is ignored.
- R6: A CRC strobe is accepted only in T1 mode with ESF selected, or in E1 mode with CRC4 selected.
- R7: A pulse density violation is flagged when the run of consecutive received zeros exceeds 15 bits. A run of exactly 15 zeros is not a violation.
- R8: A pulse density violation is flagged when the last 192 received bits hold fewer than 24 ones. No density check is made before 192 bits have been received since reset. A window holding exactly 24 ones is not a violation.
- R9: The interrupt line is high exactly when some status bit and its enable bit are both set.
- R10: In latch mode, the status output and reads show the held snapshot. A read does not clear it, and it does not change between ticks.
- R11: At each tick, the snapshot becomes the events accumulated since the previous tick, including any event in the tick cycle itself, and accumulation restarts empty.
- R12: Clearing the latch enable returns the block to live mode with the status empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_err_i | input | 1 | Frame-bit error strobe |
| mfa_err_i | input | 1 | Multiframe alignment error strobe |
| cas_err_i | input | 1 | CAS multiframe error strobe |
| crc_err_i | input | 1 | CRC error strobe |
| cfg_e1_i | input | 1 | 1 = E1 mode, 0 = T1 mode |
| cfg_crc4_i | input | 1 | CRC4 multiframing selected |
| cfg_cas_i | input | 1 | CAS signalling framing selected |
| cfg_esf_i | input | 1 | ESF framing selected (T1) |
| latch_en_i | input | 1 | Interval-latch mode enable |
| sec_tick_i | input | 1 | One-second tick strobe |
| rx_bit_i | input | 1 | Received data bit |
| rx_bit_en_i | input | 1 | Received bit valid |
| irq_en_i | input | 5 | Interrupt enables, one per status bit |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | 5 | Value captured by the last read |
| stat_o | output | 5 | Current status view |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong mode state appears at the status port one cycle after the latch enable or tick that should have moved it. Examples are a snapshot that changes between ticks, or live events leaking into the latched view. A corrupted zero-run or ones-count register shows up as a density bit set, or missing, two cycles after the offending bit. For the window count, the error only surfaces once 192 bits have been received. Masking and clear-on-read faults show on the very next read, as wrong read data or a status bit that survives the read.

// File: rtl/lerr_pkg.sv
package lerr_pkg;
    localparam int NERR  = 5;
    localparam int B_FRM = 0;
    localparam int B_MFA = 1;
    localparam int B_CAS = 2;
    localparam int B_CRC = 3;
    localparam int B_PDV = 4;

    typedef logic [NERR-1:0] err_vec_t;

    typedef enum logic [1:0] {
        ST_LIVE = 2'd0,
        ST_ARM  = 2'd1,
        ST_HOLD = 2'd2
    } lat_state_t;
endpackage

// File: rtl/lerr_qual.sv
module lerr_qual
    import lerr_pkg::*;
(
    input  logic     frm_i,
    input  logic     mfa_i,
    input  logic     cas_i,
    input  logic     crc_i,
    input  logic     pdv_i,
    input  logic     e1_i,
    input  logic     crc4_i,
    input  logic     casf_i,
    input  logic     esf_i,
    output err_vec_t evt_o
);
    logic mfa_ok;
    logic cas_ok;
    logic crc_ok;

    always_comb begin
        mfa_ok = e1_i & crc4_i;
        cas_ok = e1_i & casf_i;
        crc_ok = (~e1_i & esf_i) | (e1_i & crc4_i);
        evt_o        = '0;
        evt_o[B_FRM] = frm_i;
        evt_o[B_MFA] = mfa_i & mfa_ok;
        evt_o[B_CAS] = cas_i & cas_ok;
        evt_o[B_CRC] = crc_i & crc_ok;
        evt_o[B_PDV] = pdv_i;
    end
endmodule

// File: rtl/lerr_pdv_det.sv
module lerr_pdv_det #(
    parameter int WIN       = 192,
    parameter int MIN_ONES  = 24,
    parameter int MAX_ZEROS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    input  logic bit_en_i,
    output logic pdv_o
);
    localparam int ZW = $clog2(MAX_ZEROS + 2);
    localparam int CW = $clog2(WIN + 1);
    localparam logic [ZW-1:0] ZLIM = ZW'(MAX_ZEROS);
    localparam logic [ZW-1:0] ZSAT = ZW'(MAX_ZEROS + 1);
    localparam logic [CW-1:0] WLEN = CW'(WIN);
    localparam logic [CW-1:0] OMIN = CW'(MIN_ONES);

    logic [WIN-1:0] win_q;
    logic [CW-1:0]  ones_q, ones_nx;
    logic [CW-1:0]  fill_q, fill_nx;
    logic [ZW-1:0]  zrun_q, zrun_nx;
    logic           full, drop, viol;

    always_comb begin
        full    = (fill_q == WLEN);
        drop    = full & win_q[WIN-1];
        ones_nx = ones_q + CW'(bit_i) - CW'(drop);
        fill_nx = full ? fill_q : fill_q + CW'(1);
        if (bit_i)
            zrun_nx = '0;
        else if (zrun_q == ZSAT)
            zrun_nx = zrun_q;
        else
            zrun_nx = zrun_q + ZW'(1);
        viol = (zrun_nx > ZLIM) | ((fill_nx == WLEN) & (ones_nx < OMIN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            ones_q <= '0;
            fill_q <= '0;
            zrun_q <= '0;
            pdv_o  <= 1'b0;
        end else begin
            pdv_o <= bit_en_i & viol;
            if (bit_en_i) begin
                win_q  <= {win_q[WIN-2:0], bit_i};
                ones_q <= ones_nx;
                fill_q <= fill_nx;
                zrun_q <= zrun_nx;
            end
        end
    end

    p_run_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_en_i && !bit_i && zrun_q >= ZLIM) |=> pdv_o);
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !bit_en_i |=> !pdv_o);
    p_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        ones_q <= fill_q);
endmodule

// File: rtl/lerr_status.sv
module lerr_status
    import lerr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  err_vec_t evt_i,
    input  logic     rd_en_i,
    input  logic     latch_en_i,
    input  logic     tick_i,
    output err_vec_t view_o,
    output err_vec_t rd_data_o
);
    lat_state_t st_q, st_nx;
    err_vec_t   live_q, shadow_q, held_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_LIVE;
        else     st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_LIVE: if (latch_en_i) st_nx = ST_ARM;
            ST_ARM: begin
                if (!latch_en_i)  st_nx = ST_LIVE;
                else if (tick_i)  st_nx = ST_HOLD;
            end
            ST_HOLD: if (!latch_en_i) st_nx = ST_LIVE;
            default: st_nx = ST_LIVE;
        endcase
    end

    always_comb begin
        view_o = (st_q == ST_LIVE) ? live_q : held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q    <= '0;
            shadow_q  <= '0;
            held_q    <= '0;
            rd_data_o <= '0;
        end else begin
            if (rd_en_i) rd_data_o <= view_o;
            unique case (st_q)
                ST_LIVE: begin
                    if (latch_en_i) begin
                        live_q   <= '0;
                        shadow_q <= evt_i;
                        held_q   <= '0;
                    end else begin
                        live_q <= (rd_en_i ? '0 : live_q) | evt_i;
                    end
                end
                ST_ARM, ST_HOLD: begin
                    if (!latch_en_i) begin
                        live_q   <= '0;
                        shadow_q <= '0;
                        held_q   <= '0;
                    end else if (tick_i) begin
                        held_q   <= shadow_q | evt_i;
                        shadow_q <= '0;
                    end else begin
                        shadow_q <= shadow_q | evt_i;
                    end
                end
                default: live_q <= '0;
            endcase
        end
    end

    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LIVE && !latch_en_i && !rd_en_i)
        |=> ((live_q & $past(live_q)) == $past(live_q)));
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LIVE && !latch_en_i && rd_en_i && evt_i == '0)
        |=> (live_q == '0));
    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LIVE && !latch_en_i && rd_en_i && evt_i[B_FRM])
        |=> live_q[B_FRM]);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_LIVE && latch_en_i && !tick_i) |=> $stable(held_q));
    p_restart_r11: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_LIVE && latch_en_i && tick_i) |=> (shadow_q == '0));
    p_exit_r12: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_LIVE && !latch_en_i) |=> (view_o == '0));
endmodule

// File: rtl/line_err_mon.sv
module line_err_mon
    import lerr_pkg::*;
#(
    parameter int WIN       = 192,
    parameter int MIN_ONES  = 24,
    parameter int MAX_ZEROS = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frm_err_i,
    input  logic            mfa_err_i,
    input  logic            cas_err_i,
    input  logic            crc_err_i,
    input  logic            cfg_e1_i,
    input  logic            cfg_crc4_i,
    input  logic            cfg_cas_i,
    input  logic            cfg_esf_i,
    input  logic            latch_en_i,
    input  logic            sec_tick_i,
    input  logic            rx_bit_i,
    input  logic            rx_bit_en_i,
    input  logic [NERR-1:0] irq_en_i,
    input  logic            rd_en_i,
    output logic [NERR-1:0] rd_data_o,
    output logic [NERR-1:0] stat_o,
    output logic            irq_o
);
    logic     pdv;
    err_vec_t evt;

    lerr_pdv_det #(
        .WIN      (WIN),
        .MIN_ONES (MIN_ONES),
        .MAX_ZEROS(MAX_ZEROS)
    ) u_pdv (
        .clk     (clk),
        .rst     (rst),
        .bit_i   (rx_bit_i),
        .bit_en_i(rx_bit_en_i),
        .pdv_o   (pdv)
    );

    lerr_qual u_qual (
        .frm_i (frm_err_i),
        .mfa_i (mfa_err_i),
        .cas_i (cas_err_i),
        .crc_i (crc_err_i),
        .pdv_i (pdv),
        .e1_i  (cfg_e1_i),
        .crc4_i(cfg_crc4_i),
        .casf_i(cfg_cas_i),
        .esf_i (cfg_esf_i),
        .evt_o (evt)
    );

    lerr_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .rd_en_i   (rd_en_i),
        .latch_en_i(latch_en_i),
        .tick_i    (sec_tick_i),
        .view_o    (stat_o),
        .rd_data_o (rd_data_o)
    );

    always_comb irq_o = |(stat_o & irq_en_i);

    p_mfa_mask_r5: assert property (@(posedge clk) disable iff (rst)
        !(cfg_e1_i && cfg_crc4_i) |-> !evt[B_MFA]);
    p_cas_mask_r5: assert property (@(posedge clk) disable iff (rst)
        !(cfg_e1_i && cfg_cas_i) |-> !evt[B_CAS]);
    p_crc_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_e1_i && !cfg_esf_i) |-> !evt[B_CRC]);
    p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_en_i == '0) |-> !irq_o);
endmodule

// File: tb/line_err_mon_tb.sv
module line_err_mon_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frm = 0, mfa = 0, cas = 0, crc = 0;
    logic       e1 = 0, crc4 = 0, casf = 0, esf = 0;
    logic       latch = 0, tick = 0, rxb = 0, rxen = 0, rd = 0;
    logic [4:0] ien = 0;
    logic [4:0] rdata, stat;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 0;

    always #4 clk = ~clk;

    line_err_mon u_dut (
        .clk(clk), .rst(rst),
        .frm_err_i(frm), .mfa_err_i(mfa), .cas_err_i(cas), .crc_err_i(crc),
        .cfg_e1_i(e1), .cfg_crc4_i(crc4), .cfg_cas_i(casf), .cfg_esf_i(esf),
        .latch_en_i(latch), .sec_tick_i(tick),
        .rx_bit_i(rxb), .rx_bit_en_i(rxen),
        .irq_en_i(ien), .rd_en_i(rd),
        .rd_data_o(rdata), .stat_o(stat), .irq_o(irq)
    );

    always @(posedge clk) rd_seen <= rd;

    // monitor: pops expected read values and compares them with the read data
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [4:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s read: got %b expected %b", t, rdata, e);
            end
        end
    end

    task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string t);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", t, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic [3:0] s);
        {crc, cas, mfa, frm} = s;
        @(negedge clk);
        {crc, cas, mfa, frm} = 4'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [4:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rxen = 1'b1;
        rxb  = b;
        @(negedge clk);
        rxen = 1'b0;
    endtask

    task automatic send_pattern(input int period, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit((i % period) == 0);
        idle(3);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(1);
        do_reset();
        chk(stat, 5'b0, "R1 status");
        chk({4'b0, irq}, 5'b0, "R1 irq");
        chk(rdata, 5'b0, "R1 rdata");

        // T1, no ESF
        pulse(4'b0001);
        chk(stat, 5'b00001, "R2 frame bit set");
        idle(3);
        chk(stat, 5'b00001, "R2 sticky");
        pulse(4'b1110);
        chk(stat, 5'b00001, "R5 R6 masked in T1 non-ESF");
        do_read(5'b00001, "R3");
        chk(stat, 5'b0, "R3 cleared by read");

        // interrupt
        ien = 5'b00001;
        @(negedge clk);
        chk({4'b0, irq}, 5'b0, "R9 irq low with no status");
        pulse(4'b0001);
        chk({4'b0, irq}, 5'b1, "R9 irq high");
        ien = 5'b00010;
        @(negedge clk);
        chk({4'b0, irq}, 5'b0, "R9 irq masked");
        do_read(5'b00001, "R3 second");
        ien = 5'b0;

        // E1 CRC4
        e1 = 1; crc4 = 1;
        pulse(4'b1110);
        chk(stat, 5'b01010, "R5 R6 E1 CRC4 accepts MFA and CRC, drops CAS");
        crc4 = 0; casf = 1;
        pulse(4'b1110);
        chk(stat, 5'b01110, "R5 R6 E1 CAS accepts CAS only");
        do_read(5'b01110, "R5 R6");
        e1 = 0; casf = 0; esf = 1;
        pulse(4'b1000);
        chk(stat, 5'b01000, "R6 T1 ESF accepts CRC");
        do_read(5'b01000, "R6");

        // event in same cycle as read
        frm = 1; rd = 1;
        exp_q.push_back(5'b0); tag_q.push_back("R4 read excludes event");
        @(negedge clk);
        frm = 0; rd = 0;
        @(negedge clk);
        chk(stat, 5'b00001, "R4 event kept");
        do_read(5'b00001, "R4");

        // zero run
        do_reset();
        send_pattern(1000, 0);
        for (int i = 0; i < 15; i++) send_bit(1'b0);
        idle(3);
        chk(stat, 5'b0, "R7 15 zeros no violation");
        send_bit(1'b0);
        idle(3);
        chk(stat, 5'b10000, "R7 16 zeros violation");
        do_read(5'b10000, "R7");

        // density
        do_reset();
        send_pattern(9, 100);
        chk(stat, 5'b0, "R8 no check before window fills");
        do_reset();
        send_pattern(8, 384);
        chk(stat, 5'b0, "R8 exactly 24 ones ok");
        send_pattern(9, 192);
        chk(stat, 5'b10000, "R8 sparse ones violation");

        // latch mode
        do_reset();
        esf = 1;
        latch = 1;
        @(negedge clk);
        pulse(4'b0001);
        chk(stat, 5'b0, "R10 snapshot empty before tick");
        do_tick();
        chk(stat, 5'b00001, "R11 snapshot after tick");
        do_read(5'b00001, "R10");
        chk(stat, 5'b00001, "R10 read does not clear");
        pulse(4'b1000);
        chk(stat, 5'b00001, "R10 held between ticks");
        do_tick();
        chk(stat, 5'b01000, "R11 new interval");
        do_tick();
        chk(stat, 5'b0, "R11 shadow restarted empty");
        frm = 1; tick = 1;
        @(negedge clk);
        frm = 0; tick = 0;
        @(negedge clk);
        chk(stat, 5'b00001, "R11 tick-cycle event included");
        ien = 5'b11111;
        @(negedge clk);
        chk({4'b0, irq}, 5'b1, "R9 irq in latch mode");
        latch = 0;
        @(negedge clk);
        @(negedge clk);
        chk(stat, 5'b0, "R12 live mode empty");
        pulse(4'b0001);
        chk(stat, 5'b00001, "R12 live sticky again");

        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule